// File: doc/BRIEF.md
# Conversion Clock Source Selector and Conversion Timer

This block supplies the conversion clock for a delta-sigma converter and times each conversion. A single frequency-control pin does double duty. Held at a static level, it picks one of two internal conversion-clock rates. The low level gives the faster rate, whose first filter notch falls at 60 Hz. The high level gives the slower rate, whose first notch falls at 50 Hz. When the pin toggles, the toggling is recognised as an external conversion clock, and each rising edge then counts as one conversion-clock cycle. When the toggling stops, the block falls back to internal generation without any outside help. The filter notch always sits at the conversion-clock frequency divided by 2560.

The internal oscillators are modelled as divided enables of the reference clock. A conversion begins on a start pulse. It ends with a one-cycle done pulse after a fixed number of conversion-clock cycles, 20510 by default. Outside a conversion, the block emits a serial-clock enable once every eight conversion-clock cycles, so a 24-bit readout in internal serial-clock mode spans 192 conversion-clock cycles.

A change of source or rate during a conversion only stretches or shrinks that one conversion; later conversions run normally. All pins are plain control and status signals. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `conv_clk_timer`

## Requirements
- R1: During and directly after reset, `conv_done` and `sck_en` are 0 and `clk_src` is 0.
- R2: With `freq_ctl` held low, `clk_src` reads 0 and the tick period is `DIV_FAST` reference cycles. `conv_done` rises `CONV_CYCLES*DIV_FAST` clock edges after the edge that samples `conv_start`.
- R3: With `freq_ctl` held high, `clk_src` reads 1 and a conversion takes `CONV_CYCLES*DIV_SLOW` edges, counted in the same way as in R2.
- R4: `conv_done` is high for exactly one cycle, and only at the end of a conversion.
- R5: A `conv_start` pulse that arrives while a conversion is running is ignored. The running conversion ends at its original time, and `conv_done` pulses only once.
- R6: Two edges of the synchronised `freq_ctl` seen within `DET_WINDOW` reference cycles set `clk_src` to 2 (external). Each rising edge then counts as one conversion tick.
- R7: After `DET_WINDOW` reference cycles with no edge, `clk_src` leaves 2 and returns to the internal rate given by the static level. The next conversion has the exact internal length.
- R8: Outside a conversion, `sck_en` pulses once every `SCK_DIV` conversion ticks. It is never high while a conversion is running.
- R9: A single level change on `freq_ctl` with no second edge inside the window never sets `clk_src` to 2.
- R10: If the source changes in the middle of a conversion, that conversion still ends with exactly one `conv_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freq_ctl | input | 1 | Asynchronous rate select level or external conversion clock |
| conv_start | input | 1 | One-cycle request to begin a conversion |
| conv_done | output | 1 | One-cycle pulse at the end of a conversion |
| clk_src | output | 2 | 0 internal fast, 1 internal slow, 2 external |
| sck_en | output | 1 | Serial-clock enable, one pulse per SCK_DIV ticks while idle |

## Verification
The bench builds the block with `DIV_FAST`=1 and `DIV_SLOW`=2 and keeps the full 20510-tick conversion length. Exact end-of-conversion counts for both internal rates therefore fit in the run, along with an external-clock conversion and one with a source switch partway through. `DET_WINDOW`=16 brings detection, loss of the external clock and the single-edge case within a few dozen cycles. `SCK_DIV`=8 makes the serial-enable interval directly measurable at each source.

// File: rtl/conv_clk_pkg.sv
package conv_clk_pkg;
  typedef enum logic [1:0] {
    SRC_INT_FAST = 2'd0,
    SRC_INT_SLOW = 2'd1,
    SRC_EXT      = 2'd2
  } clk_src_e;
endpackage

// File: rtl/fctl_monitor.sv
// Synchronises the frequency-control pin, reports its level and edges,
// and decides whether a toggling external clock is present.
module fctl_monitor #(
  parameter int SYNC_STAGES = 2,
  parameter int DET_WINDOW  = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic edge_ev,
  output logic rise,
  output logic present
);
  localparam int GW = $clog2(DET_WINDOW + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(DET_WINDOW - 1);

  logic [SYNC_STAGES:0] sh;
  logic [GW-1:0]        gap;
  logic                 armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC_STAGES-1:0], pin};
  end

  assign lvl     = sh[SYNC_STAGES-1];
  assign edge_ev = sh[SYNC_STAGES-1] ^ sh[SYNC_STAGES];
  assign rise    = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];

  // gap saturates at its last value while the pin is quiet
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap     <= GAP_LAST;
      armed   <= 1'b0;
      present <= 1'b0;
    end else if (edge_ev) begin
      gap   <= '0;
      armed <= 1'b1;
      if (armed) present <= 1'b1;
    end else if (gap >= GAP_LAST) begin
      armed   <= 1'b0;
      present <= 1'b0;
    end else begin
      gap <= gap + 1'b1;
    end
  end
endmodule

// File: rtl/conv_tick_gen.sv
// Produces the conversion-clock tick from a reference divider or the
// external edges, and reports the active source.
module conv_tick_gen
  import conv_clk_pkg::*;
#(
  parameter int DIV_FAST = 326,
  parameter int DIV_SLOW = 391
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     restart,
  input  logic     ext_present,
  input  logic     lvl,
  input  logic     ext_rise,
  output logic     tick,
  output clk_src_e src
);
  localparam int DMAX = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
  localparam int DW   = $clog2(DMAX) + 1;

  logic [DW-1:0] dcnt;
  logic [DW-1:0] lim;
  logic          int_tick;

  assign lim      = lvl ? DW'(DIV_SLOW - 1) : DW'(DIV_FAST - 1);
  assign int_tick = (dcnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      dcnt <= '0;
    else if (restart || ext_present) dcnt <= '0;
    else if (int_tick)               dcnt <= '0;
    else                             dcnt <= dcnt + 1'b1;
  end

  assign tick = ext_present ? ext_rise : int_tick;

  always_comb begin
    if (ext_present) src = SRC_EXT;
    else if (lvl)    src = SRC_INT_SLOW;
    else             src = SRC_INT_FAST;
  end
endmodule

// File: rtl/conv_sequencer.sv
// Counts conversion ticks from start to done and divides idle ticks
// into the serial-clock enable.
module conv_sequencer #(
  parameter int CONV_CYCLES = 20510,
  parameter int SCK_DIV     = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic                           tick,
  output logic                           accept,
  output logic                           busy,
  output logic                           done,
  output logic                           sck_en,
  output logic [$clog2(CONV_CYCLES)-1:0] tcnt
);
  localparam int TW = $clog2(CONV_CYCLES);
  localparam int SW = $clog2(SCK_DIV + 1);
  localparam logic [TW-1:0] T_LAST = TW'(CONV_CYCLES - 1);
  localparam logic [SW-1:0] S_LAST = SW'(SCK_DIV - 1);

  logic [SW-1:0] scnt;

  assign accept = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      tcnt <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        tcnt <= '0;
      end else if (busy && tick) begin
        if (tcnt == T_LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
          tcnt <= '0;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt   <= '0;
      sck_en <= 1'b0;
    end else begin
      sck_en <= 1'b0;
      if (busy || start) begin
        scnt <= '0;
      end else if (tick) begin
        if (scnt == S_LAST) begin
          scnt   <= '0;
          sck_en <= 1'b1;
        end else begin
          scnt <= scnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/conv_clk_timer.sv
module conv_clk_timer
  import conv_clk_pkg::*;
#(
  parameter int DIV_FAST    = 326,
  parameter int DIV_SLOW    = 391,
  parameter int CONV_CYCLES = 20510,
  parameter int DET_WINDOW  = 10000,
  parameter int SCK_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       freq_ctl,
  input  logic       conv_start,
  output logic       conv_done,
  output logic [1:0] clk_src,
  output logic       sck_en
);
  localparam int TW = $clog2(CONV_CYCLES);

  logic          lvl, edge_ev, ext_rise, ext_present;
  logic          tick, accept, busy;
  logic [TW-1:0] tcnt;
  clk_src_e      src;

  fctl_monitor #(.SYNC_STAGES(SYNC_STAGES), .DET_WINDOW(DET_WINDOW)) u_mon (
    .clk(clk), .rst_n(rst_n), .pin(freq_ctl),
    .lvl(lvl), .edge_ev(edge_ev), .rise(ext_rise), .present(ext_present)
  );

  conv_tick_gen #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(accept), .ext_present(ext_present),
    .lvl(lvl), .ext_rise(ext_rise), .tick(tick), .src(src)
  );

  conv_sequencer #(.CONV_CYCLES(CONV_CYCLES), .SCK_DIV(SCK_DIV)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(conv_start), .tick(tick),
    .accept(accept), .busy(busy), .done(conv_done), .sck_en(sck_en),
    .tcnt(tcnt)
  );

  assign clk_src = src;
endmodule

// File: rtl/conv_clk_timer_chk.sv
module conv_clk_timer_chk #(
  parameter int CONV_CYCLES = 20510
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           conv_start,
  input logic                           conv_done,
  input logic                           sck_en,
  input logic [1:0]                     clk_src,
  input logic                           busy,
  input logic                           edge_ev,
  input logic [$clog2(CONV_CYCLES)-1:0] tcnt
);
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !conv_done);

  p_done_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> $past(busy));

  p_sck_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sck_en);

  p_ext_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_src == 2'd2) |-> $past(edge_ev));

  p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && conv_start && tcnt != '0) |=> (tcnt != '0 || conv_done));

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(tcnt) < CONV_CYCLES));
endmodule

bind conv_clk_timer conv_clk_timer_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
  .sck_en(sck_en), .clk_src(clk_src), .busy(busy), .edge_ev(edge_ev),
  .tcnt(tcnt)
);

// File: tb/sim_conv_clk_timer.sv
module sim_conv_clk_timer;
  localparam int NCONV = 20510;
  localparam int DF = 1;
  localparam int DS = 2;
  localparam int WIN = 16;
  localparam int SD = 8;

  logic clk = 0, rst_n = 0, conv_start = 0;
  logic fctl_lvl = 0, ext_on = 0, ext_clk = 0;
  logic freq_ctl, conv_done, sck_en;
  logic [1:0] clk_src;

  int checks = 0, errors = 0, cyc = 0, done_cnt = 0, t0 = 0;
  bit in_conv = 0, finished = 0;
  int exp_q[$];
  int tol_q[$];
  string tag_q[$];

  assign freq_ctl = ext_on ? ext_clk : fctl_lvl;

  conv_clk_timer #(.DIV_FAST(DF), .DIV_SLOW(DS), .CONV_CYCLES(NCONV),
                   .DET_WINDOW(WIN), .SCK_DIV(SD)) u0 (
    .clk(clk), .rst_n(rst_n), .freq_ctl(freq_ctl), .conv_start(conv_start),
    .conv_done(conv_done), .clk_src(clk_src), .sck_en(sck_en));

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;
  always @(negedge clk) ext_clk <= ~ext_clk;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: compares each done against the scoreboard
  always @(negedge clk) begin
    if (rst_n && conv_done) begin
      int meas, e, t;
      string tg;
      done_cnt++;
      meas = cyc - t0;
      if (exp_q.size() == 0) begin
        check(0, "R5 unexpected done", done_cnt, done_cnt - 1);
      end else begin
        e = exp_q.pop_front(); t = tol_q.pop_front(); tg = tag_q.pop_front();
        check((meas >= e - t) && (meas <= e + t), tg, meas, e);
      end
      in_conv = 0;
    end else if (in_conv && sck_en) begin
      check(0, "R8 sck_en during conversion", 1, 0);
    end
  end

  task automatic issue_start(input int expv, input int tol, input string tag);
    @(negedge clk); conv_start = 1;
    @(negedge clk); conv_start = 0;
    t0 = cyc; in_conv = 1;
    exp_q.push_back(expv); tol_q.push_back(tol); tag_q.push_back(tag);
  endtask

  task automatic wait_done();
    int target = done_cnt + 1;
    while (done_cnt < target) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic sck_interval(input int expv, input string tag);
    int t1;
    @(negedge clk);
    while (!sck_en) @(negedge clk);
    t1 = cyc;
    @(negedge clk);
    while (!sck_en) @(negedge clk);
    check(cyc - t1 == expv, tag, cyc - t1, expv);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int bad;
    // R1 reset state
    repeat (4) @(negedge clk);
    check(conv_done == 0, "R1 done in reset", conv_done, 0);
    check(sck_en == 0, "R1 sck_en in reset", sck_en, 0);
    check(clk_src == 0, "R1 src in reset", clk_src, 0);
    rst_n = 1;
    @(negedge clk);
    check(conv_done == 0 && clk_src == 0, "R1 after reset", clk_src, 0);

    // R2 fast internal rate, with R5 second start ignored
    repeat (10) @(negedge clk);
    check(clk_src == 0, "R2 src fast", clk_src, 0);
    issue_start(NCONV * DF, 0, "R2 fast conversion length");
    repeat (100) @(negedge clk);
    conv_start = 1; @(negedge clk); conv_start = 0;   // R5 ignored
    wait_done();
    repeat (40) @(negedge clk);
    check(done_cnt == 1, "R5 single done", done_cnt, 1);
    sck_interval(SD * DF, "R8 sck interval fast");

    // R9 single edge does not select external
    fctl_lvl = 1;
    bad = 0;
    repeat (WIN + 10) begin
      @(negedge clk);
      if (clk_src == 2) bad++;
    end
    check(bad == 0, "R9 single edge no ext", bad, 0);
    check(clk_src == 1, "R3 src slow", clk_src, 1);

    // R3 slow internal rate
    issue_start(NCONV * DS, 0, "R3 slow conversion length");
    wait_done();
    sck_interval(SD * DS, "R8 sck interval slow");

    // R6 external clock detection and conversion
    ext_on = 1;
    repeat (12) @(negedge clk);
    check(clk_src == 2, "R6 ext detected", clk_src, 2);
    issue_start(NCONV * 2, 3, "R6 ext conversion length");
    wait_done();
    sck_interval(SD * 2, "R8 sck interval ext");

    // R10 external clock lost mid-conversion
    fctl_lvl = 0;
    issue_start(21530, 30, "R10 mixed conversion completes");
    repeat (2000) @(negedge clk);
    ext_on = 0;
    repeat (4) @(negedge clk);
    check(clk_src == 2, "R7 ext held inside window", clk_src, 2);
    repeat (WIN + 8) @(negedge clk);
    check(clk_src == 0, "R7 fallback to internal", clk_src, 0);
    wait_done();
    check(done_cnt == 4, "R10 one done per conversion", done_cnt, 4);

    // R7 next conversion exact internal length
    issue_start(NCONV * DF, 0, "R7 post-fallback conversion length");
    wait_done();
    check(exp_q.size() == 0, "R4 all conversions completed", exp_q.size(), 0);
    finish_run();
  end
endmodule